// File: doc/BRIEF.md
# Receive Symbol Order Aligner

This block sits on a receive datapath right after a 2:1 deserializer. Each parallel word carries two symbols of `SYM_W` bits (8 or 10). Bits `[SYM_W-1:0]` are the lower lane, which comes first in time. Bits `[2*SYM_W-1:SYM_W]` are the upper lane. A programmable ordering pattern belongs in the lower lane. When the pattern turns up in the upper lane instead, the block inserts one programmable pad symbol into the stream. From that point the pattern and everything after it arrive one symbol later, and the pattern lands in the lower lane.

After an insertion the block keeps the one-symbol offset. It holds the upper symbol of each incoming word and sends it out as the lower symbol of the next output word. Only reset returns the block to plain pass-through with no offset.

Ordering can run in one of two modes:
- **Automatic mode:** ordering is attempted on every valid word.
- **Manual mode:** ordering needs the enable input to be high, and the enable must have been seen low since reset or since the last ordering event.

Every ordering event is reported on a one-cycle flag. The flag is aligned with the output word that carries the pad.

Top module: `rx_sym_order_align`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid` and `order_flag` are 0. The block starts with no symbol offset.
- R2: With no offset and no ordering, each valid input word appears unchanged on `out_data` one clock later.
- R3: `out_valid` equals `in_valid` delayed by exactly one clock.
- R4: An ordering event is triggered by a valid word at zero offset whose upper lane equals `cfg_pattern` and whose lower lane does not, provided the mode permits it. One clock later the output has lower lane = that input's lower symbol, upper lane = `cfg_pad`, and `order_flag` = 1.
- R5: Once the offset is set, each valid output word has lower lane = the previous valid input's upper symbol and upper lane = the current input's lower symbol. Only the single pad is added to the symbol stream. No symbol is lost or repeated, even across invalid cycles.
- R6: A word whose lower lane equals the pattern causes no ordering. This holds even when the upper lane also equals the pattern.
- R7: `order_flag` is high for one cycle per event and only together with `out_valid`.
- R8: In manual mode (`cfg_manual`=1), no ordering takes place while `order_en` is 0.
- R9: In manual mode, an ordering needs `order_en` = 1 in the pattern's cycle, and `order_en` must have been 0 in some earlier cycle since reset or since the last ordering. If the enable is held high from reset, the pattern is ignored.
- R10: After one ordering event, no further ordering occurs until reset, whatever the pattern positions or enable activity.
- R11: Cycles with `in_valid` = 0 change neither the offset nor the held symbol, and trigger no ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 2*SYM_W | Deserialized word; lower lane first in time |
| in_valid | input | 1 | `in_data` holds a word this cycle |
| cfg_pattern | input | SYM_W | Ordering pattern to search for |
| cfg_pad | input | SYM_W | Pad symbol inserted on an ordering event |
| cfg_manual | input | 1 | 0 = automatic mode, 1 = manual mode |
| order_en | input | 1 | Manual-mode ordering enable, re-armed by a low cycle |
| out_data | output | 2*SYM_W | Reordered word |
| out_valid | output | 1 | `out_data` holds a word this cycle |
| order_flag | output | 1 | High in the cycle the pad word is output |

## Verification
Two functions can fall in the same clock edge:
- **Enable arming and pattern detection:** in manual mode the cycle that completes arming (enable rising after a low cycle) can also carry the misplaced pattern. The bench drives the enable low for the first two cycles and puts the pattern in the upper lane of the very first word that sees the enable high. It then expects the pad word and the flag one clock later.
- **Carry path and valid gaps:** the carry path across an invalid cycle can coincide with the insertion. The pattern position is swept over every symbol slot, both with and without a gap every third cycle. Each output word is compared with a stream model that places exactly one pad in front of the first misplaced pattern.

// File: rtl/rxso_pkg.sv
// Package rxso_pkg
// Shared definitions for the receive symbol order aligner.
// Assumes a word of exactly two symbols, lower lane first in time.
package rxso_pkg;

    typedef enum logic [0:0] {
        ORD_AUTO   = 1'b0,
        ORD_MANUAL = 1'b1
    } ord_mode_e;

    localparam int unsigned LANES    = 2;
    localparam int unsigned LANE_LO  = 0;
    localparam int unsigned LANE_HI  = 1;

endpackage

// File: rtl/rxso_detect.sv
// Module rxso_detect
// Decides in the current cycle whether an ordering event happens.
// It compares the pattern against both lanes, applies the mode rules
// and keeps the manual-mode arm bit. The arm bit is set by any cycle
// with the enable low and cleared by a manual ordering event.
// Assumes the offset indication comes from the lane shifter.
module rxso_detect
    import rxso_pkg::*;
#(
    parameter int unsigned SYM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SYM_W-1:0] in_lo,
    input  logic [SYM_W-1:0] in_hi,
    input  logic [SYM_W-1:0] pattern,
    input  ord_mode_e        mode,
    input  logic             enable,
    input  logic             shifted,
    output logic             hit
);

    localparam int unsigned WORD_W = LANES * SYM_W;

    logic [WORD_W-1:0] word;
    logic [LANES-1:0]  lane_match;
    logic              armed_q;
    logic              permit;

    assign word = {in_hi, in_lo};

    // One comparator per lane against the programmed pattern.
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane_cmp
            assign lane_match[l] = (word[l*SYM_W +: SYM_W] == pattern);
        end
    endgenerate

    // Mode gate: automatic always permits, manual needs an armed enable.
    always_comb begin
        permit = (mode == ORD_AUTO) || (enable && armed_q);
    end

    // Event: misplaced pattern at zero offset on a valid word.
    always_comb begin
        hit = in_valid && !shifted && lane_match[LANE_HI]
              && !lane_match[LANE_LO] && permit;
    end

    // Arm bit: a low enable arms, a manual event consumes the arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (!enable) begin
            armed_q <= 1'b1;
        end else if (hit && (mode == ORD_MANUAL)) begin
            armed_q <= 1'b0;
        end
    end

    p_manual_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ORD_MANUAL && !enable) |-> !hit);

    p_lower_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_lo == pattern) |-> !hit);

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        shifted |-> !hit);

    p_idle_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !hit);

endmodule

// File: rtl/rxso_lane_shift.sv
// Module rxso_lane_shift
// Registered datapath: pass-through at zero offset, pad insertion on an
// event, and a one-symbol carry afterwards. It also registers valid and
// the event flag so that all outputs share one cycle of latency.
// Assumes hit is only raised on a valid word at zero offset.
module rxso_lane_shift #(
    parameter int unsigned SYM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SYM_W-1:0] in_lo,
    input  logic [SYM_W-1:0] in_hi,
    input  logic [SYM_W-1:0] pad,
    input  logic             hit,
    output logic [SYM_W-1:0] out_lo,
    output logic [SYM_W-1:0] out_hi,
    output logic             out_valid,
    output logic             flag,
    output logic             shifted
);

    logic             shift_q;
    logic [SYM_W-1:0] held_q;
    logic [SYM_W-1:0] nxt_lo;
    logic [SYM_W-1:0] nxt_hi;
    logic [SYM_W-1:0] nxt_held;
    logic             nxt_shift;

    assign shifted = shift_q;

    // Next-word selection for the three datapath cases.
    always_comb begin
        nxt_lo    = in_lo;
        nxt_hi    = in_hi;
        nxt_held  = held_q;
        nxt_shift = shift_q;
        if (hit) begin
            nxt_hi    = pad;
            nxt_held  = in_hi;
            nxt_shift = 1'b1;
        end else if (shift_q) begin
            nxt_lo   = held_q;
            nxt_hi   = in_lo;
            nxt_held = in_hi;
        end
    end

    // Offset state and held symbol advance only on valid words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= 1'b0;
            held_q  <= '0;
        end else if (in_valid) begin
            shift_q <= nxt_shift;
            held_q  <= nxt_held;
        end
    end

    // Output word register, loaded on valid words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_lo <= '0;
            out_hi <= '0;
        end else if (in_valid) begin
            out_lo <= nxt_lo;
            out_hi <= nxt_hi;
        end
    end

    // Valid and event flag pipeline, one stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            flag      <= 1'b0;
        end else begin
            out_valid <= in_valid;
            flag      <= hit && in_valid;
        end
    end

    p_valid_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_q && in_valid) |=> (out_lo == $past(held_q)) && (out_hi == $past(in_lo)));

    p_offset_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        shift_q |=> shift_q);

    p_hold_on_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(held_q) && $stable(shift_q));

endmodule

// File: rtl/rx_sym_order_align.sv
// Module rx_sym_order_align
// Top of the receive symbol order aligner. It splits the word into lanes,
// decides on ordering events and drives the shifted datapath.
// Assumes a two-symbol word with the lower lane first in time, and
// configuration inputs that are stable while traffic flows.
module rx_sym_order_align
    import rxso_pkg::*;
#(
    parameter int unsigned SYM_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*SYM_W-1:0]     in_data,
    input  logic                   in_valid,
    input  logic [SYM_W-1:0]       cfg_pattern,
    input  logic [SYM_W-1:0]       cfg_pad,
    input  logic                   cfg_manual,
    input  logic                   order_en,
    output logic [2*SYM_W-1:0]     out_data,
    output logic                   out_valid,
    output logic                   order_flag
);

    logic [SYM_W-1:0] in_lo;
    logic [SYM_W-1:0] in_hi;
    logic [SYM_W-1:0] out_lo;
    logic [SYM_W-1:0] out_hi;
    logic             hit;
    logic             shifted;
    ord_mode_e        mode;

    // Lane split and mode decode.
    always_comb begin
        in_lo = in_data[SYM_W-1:0];
        in_hi = in_data[2*SYM_W-1:SYM_W];
        mode  = cfg_manual ? ORD_MANUAL : ORD_AUTO;
    end

    rxso_detect #(
        .SYM_W (SYM_W)
    ) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_lo    (in_lo),
        .in_hi    (in_hi),
        .pattern  (cfg_pattern),
        .mode     (mode),
        .enable   (order_en),
        .shifted  (shifted),
        .hit      (hit)
    );

    rxso_lane_shift #(
        .SYM_W (SYM_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_lo     (in_lo),
        .in_hi     (in_hi),
        .pad       (cfg_pad),
        .hit       (hit),
        .out_lo    (out_lo),
        .out_hi    (out_hi),
        .out_valid (out_valid),
        .flag      (order_flag),
        .shifted   (shifted)
    );

    assign out_data = {out_hi, out_lo};

    p_flag_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        order_flag |-> out_valid);

    p_flag_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        order_flag |=> !order_flag);

    p_pad_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> order_flag && (out_data[2*SYM_W-1:SYM_W] == $past(cfg_pad))
                && (out_data[SYM_W-1:0] == $past(in_data[SYM_W-1:0])));

endmodule

// File: tb/rx_sym_order_align_bench.sv
`timescale 1ns/1ps
module rx_sym_order_align_bench;

    localparam int SYM_W = 10;
    localparam int NW    = 16;
    localparam int MAXC  = 40;
    localparam logic [SYM_W-1:0] PAT = 10'h3BC;
    localparam logic [SYM_W-1:0] PAD = 10'h2AA;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [2*SYM_W-1:0] in_data = '0;
    logic               in_valid = 1'b0;
    logic               cfg_manual = 1'b0;
    logic               order_en = 1'b0;
    logic [2*SYM_W-1:0] out_data;
    logic               out_valid;
    logic               order_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [2*SYM_W-1:0] drv_d [MAXC];
    bit                 drv_v [MAXC];
    bit                 drv_e [MAXC];
    logic [2*SYM_W-1:0] exp_d [MAXC];
    bit                 exp_f [MAXC];

    always #2 clk = ~clk;

    rx_sym_order_align #(.SYM_W(SYM_W)) u_rx_sym_order_align (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_data     (in_data),
        .in_valid    (in_valid),
        .cfg_pattern (PAT),
        .cfg_pad     (PAD),
        .cfg_manual  (cfg_manual),
        .order_en    (order_en),
        .out_data    (out_data),
        .out_valid   (out_valid),
        .order_flag  (order_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic logic [SYM_W-1:0] sym_at(input int j, input logic [31:0] pm);
        if (j < 32 && pm[j]) return PAT;
        return SYM_W'((j % 200) + 1);
    endfunction

    // Expected output stream: one pad placed before the ordered pattern.
    function automatic logic [SYM_W-1:0] exp_at(input int j, input int opos, input logic [31:0] pm);
        if (opos < 0 || j < opos) return sym_at(j, pm);
        if (j == opos) return PAD;
        return sym_at(j - 1, pm);
    endfunction

    task automatic run_case(input string tag, input bit man, input logic [31:0] pm,
                            input bit gap, input logic [MAXC-1:0] enm, input int want_pos);
        int w = 0;
        int opos = -1;
        int nc = 0;
        bit armed = 1'b0;
        for (int c = 0; c < MAXC && w < NW; c++) begin
            logic [SYM_W-1:0] lo;
            logic [SYM_W-1:0] hi;
            bit hitc;
            drv_v[c] = !(gap && (c % 3 == 2));
            drv_e[c] = enm[c];
            exp_f[c] = 1'b0;
            exp_d[c] = '0;
            drv_d[c] = '0;
            hitc = 1'b0;
            if (drv_v[c]) begin
                lo = sym_at(2*w, pm);
                hi = sym_at(2*w + 1, pm);
                drv_d[c] = {hi, lo};
                hitc = (opos < 0) && (hi == PAT) && (lo != PAT) && (!man || (enm[c] && armed));
                if (hitc) opos = 2*w + 1;
                exp_f[c] = hitc;
                exp_d[c] = {exp_at(2*w + 1, opos, pm), exp_at(2*w, opos, pm)};
                w++;
            end
            if (!enm[c]) armed = 1'b1;
            else if (hitc && man) armed = 1'b0;
            nc = c + 1;
        end
        chk(opos == want_pos, {tag, " model position"}, 32'(opos), 32'(want_pos));
        // Reset phase
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; order_en = 1'b0; cfg_manual = man;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0 && order_flag == 1'b0, "R1 reset outputs",
            {30'd0, out_valid, order_flag}, 32'd0);
        rst_n = 1'b1;
        for (int c = 0; c < nc; c++) begin
            in_data  = drv_d[c];
            in_valid = drv_v[c];
            order_en = drv_e[c];
            @(negedge clk);
            chk(out_valid == drv_v[c], {tag, " R3 valid latency"}, 32'(out_valid), 32'(drv_v[c]));
            chk(order_flag == exp_f[c], {tag, " R4 R7 R8 R9 R10 flag"}, 32'(order_flag), 32'(exp_f[c]));
            if (drv_v[c])
                chk(out_data == exp_d[c], {tag, " R2 R5 R6 R11 data"}, 32'(out_data), 32'(exp_d[c]));
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && order_flag == 1'b0, {tag, " R3 drain"},
            {30'd0, out_valid, order_flag}, 32'd0);
    endtask

    initial begin
        // R2 R4 R5 R11: automatic mode, pattern swept over every slot, with and without gaps
        for (int g = 0; g < 2; g++) begin
            for (int p = 0; p < 2*NW; p++) begin
                run_case($sformatf("auto sweep p=%0d gap=%0d", p, g), 1'b0,
                         32'd1 << p, g[0], '1, (p % 2 == 1) ? p : -1);
            end
        end
        // R6: pattern in both lanes is left alone, a later misplaced one is ordered
        run_case("R6 both lanes", 1'b0, (32'd1 << 4) | (32'd1 << 5) | (32'd1 << 9), 1'b0, '1, 9);
        // R10: only the first misplaced pattern gets a pad
        run_case("R10 sticky", 1'b0, (32'd1 << 3) | (32'd1 << 10) | (32'd1 << 13), 1'b1, '1, 3);
        // R8: manual mode with enable low never orders
        run_case("R8 manual idle", 1'b1, 32'd1 << 5, 1'b0, '0, -1);
        // R9: enable high from reset ignores the pattern; low cycle then re-arms
        run_case("R9 rearm", 1'b1, (32'd1 << 5) | (32'd1 << 29), 1'b0,
                 ~(40'd1 << 12), 29);
        // R9: arming completes on the same cycle the pattern arrives
        run_case("R9 arm and hit", 1'b1, 32'd1 << 5, 1'b0, ~40'd3, 5);
        // R9 R10: manual re-arm after an event does not allow a second pad
        run_case("R10 manual rearm", 1'b1, (32'd1 << 5) | (32'd1 << 20), 1'b0,
                 ~(40'd1 | (40'd1 << 6)), 5);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule